// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core runs one instruction per clock cycle from a small fixed set: word load, word store, five register-to-register operations (add, subtract, bitwise AND, bitwise OR and signed set-less-than), branch-if-equal and an absolute jump. All of the work for an instruction happens in the same cycle. The instruction is fetched, the registers are read, the ALU computes, data memory is accessed and the result is written back. The program counter and the register file update on the next rising edge.

Instruction memory and data memory sit outside the core and are both read combinationally. The core drives `instrAddr` and takes the word back on `instrData`. For data, it drives an address, write data and a write strobe, and it reads the load result from `dataRdData`. Memory writes take effect on the rising edge.

Internally, a control decoder turns the opcode and function fields into a packed struct of strobes. The datapath holds the program counter, the 32-entry register file, the ALU and the next-PC selection.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge sets the program counter, and with it `instrAddr`, to 0.
- R2: Every instruction that is neither a jump nor a taken branch advances `instrAddr` by exactly 4.
- R3: An R-type word has opcode bits [31:26]=000000, rs in [25:21], rt in [20:16] and rd in [15:11]. Function code [5:0] selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 signed set-less-than (result 1 or 0). The result is written to rd.
- R4: A load (opcode 100011) drives `dataAddr` = rs + sign-extended imm[15:0] and writes `dataRdData` into rt.
- R5: A store (opcode 101011) drives `dataWe`=1, `dataAddr` = rs + sign-extended imm and `dataWrData` = rt. It writes no register.
- R6: Branch-if-equal (opcode 000100) sets the PC to PC+4 + (sign-extended imm << 2) when rs equals rt, and to PC+4 otherwise. Negative offsets are allowed.
- R7: A jump (opcode 000010) sets the PC to {PC[31:28], instr[25:0], 2'b00}.
- R8: Register 0 always reads as zero. Writes to it by R-type or load instructions are discarded.
- R9: Any other opcode, and an R-type word with any other function code, writes no register and no memory, and advances the PC by 4.
- R10: `dataWe` is high only while a store instruction is being executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instrAddr | output | 32 | Byte address of the current instruction |
| instrData | input | 32 | Instruction word at `instrAddr` |
| dataAddr | output | 32 | Data memory byte address (ALU result) |
| dataWrData | output | 32 | Store data |
| dataWe | output | 1 | Data memory write strobe |
| dataRdData | input | 32 | Data memory read word at `dataAddr` |

## Verification
Every ALU operation is swept over every ordered pair of six operands, including zero, -3, the largest positive value and the most negative value. This catches an unsigned set-less-than, which would invert the result for the mixed-sign pairs, and any swapped function decode.

A load with a negative offset catches a zero-extending immediate, which would fetch from far above the intended word. A branch with a negative offset catches the same fault in the branch target, and a short counted loop makes the PC trace diverge if the equality test is inverted.

Writes to register 0 and words with undefined opcodes or function codes are each followed by a store of the register concerned. A design that lets such a write land stores a nonzero or altered value, and one that mistreats an undefined word also breaks the cycle-by-cycle PC comparison.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } aluSel_e;

  typedef struct packed {
    logic    regWrite;
    logic    dstIsRd;
    logic    srcIsImm;
    logic    memWrite;
    logic    loadToReg;
    logic    branch;
    logic    jump;
    aluSel_e aluSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  output ctrlStrobes_t strb
);
  logic [1:0] aluOp;
  logic       functOk;
  aluSel_e    fnSel;

  // operation class from the opcode
  always_comb begin
    strb  = '0;
    aluOp = 2'b00;
    case (opcode)
      OP_RTYPE: begin
        aluOp        = 2'b10;
        strb.dstIsRd = 1'b1;
        strb.regWrite = functOk;
      end
      OP_LOAD: begin
        strb.regWrite  = 1'b1;
        strb.srcIsImm  = 1'b1;
        strb.loadToReg = 1'b1;
      end
      OP_STORE: begin
        strb.srcIsImm = 1'b1;
        strb.memWrite = 1'b1;
      end
      OP_BEQ: begin
        aluOp       = 2'b01;
        strb.branch = 1'b1;
      end
      OP_JUMP: strb.jump = 1'b1;
      default: ;
    endcase
    case (aluOp)
      2'b01:   strb.aluSel = ALU_SUB;
      2'b10:   strb.aluSel = fnSel;
      default: strb.aluSel = ALU_ADD;
    endcase
  end

  // function-field decode used when the class defers to it
  always_comb begin
    functOk = 1'b1;
    fnSel   = ALU_ADD;
    case (funct)
      FN_ADD:  fnSel = ALU_ADD;
      FN_SUB:  fnSel = ALU_SUB;
      FN_AND:  fnSel = ALU_AND;
      FN_OR:   fnSel = ALU_OR;
      FN_SLT:  fnSel = ALU_SLT;
      default: functOk = 1'b0;
    endcase
  end

  // R6: the equality test relies on a subtract
  always_comb begin
    if (strb.branch) a_r6_branch_uses_sub: assert (strb.aluSel == ALU_SUB);
  end
endmodule

// File: rtl/sc_dpath.sv
module sc_dpath
  import sc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strb,
  output logic [DATA_W-1:0] instrAddr,
  input  logic [DATA_W-1:0] instrData,
  output logic [DATA_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataWrData,
  input  logic [DATA_W-1:0] dataRdData
);
  localparam int REG_N = 1 << REG_AW;

  logic [DATA_W-1:0] pc, pcPlus4, pcNext, brTarget, jmpTarget;
  logic [DATA_W-1:0] regs [REG_N];
  logic [REG_AW-1:0] rsAddr, rtAddr, wrAddr;
  logic [DATA_W-1:0] rsData, rtData, wrData, immExt, srcB, aluRes;
  logic              aluZero;

  assign rsAddr = instrData[25:21];
  assign rtAddr = instrData[20:16];
  assign immExt = {{(DATA_W-16){instrData[15]}}, instrData[15:0]};

  // register file: combinational read, edge write, entry 0 fixed at zero
  assign rsData = (rsAddr == '0) ? '0 : regs[rsAddr];
  assign rtData = (rtAddr == '0) ? '0 : regs[rtAddr];
  assign wrAddr = strb.dstIsRd ? instrData[15:11] : rtAddr;
  assign wrData = strb.loadToReg ? dataRdData : aluRes;

  always_ff @(posedge clk) begin
    if (strb.regWrite && wrAddr != '0) regs[wrAddr] <= wrData;
  end

  // ALU
  assign srcB = strb.srcIsImm ? immExt : rtData;
  always_comb begin
    case (strb.aluSel)
      ALU_SUB: aluRes = rsData - srcB;
      ALU_AND: aluRes = rsData & srcB;
      ALU_OR:  aluRes = rsData | srcB;
      ALU_SLT: aluRes = {{(DATA_W-1){1'b0}}, $signed(rsData) < $signed(srcB)};
      default: aluRes = rsData + srcB;
    endcase
  end
  assign aluZero = (aluRes == '0);

  // next PC selection
  assign pcPlus4   = pc + DATA_W'(4);
  assign brTarget  = pcPlus4 + {immExt[DATA_W-3:0], 2'b00};
  assign jmpTarget = {pc[DATA_W-1:28], instrData[25:0], 2'b00};
  always_comb begin
    if (strb.jump)                  pcNext = jmpTarget;
    else if (strb.branch && aluZero) pcNext = brTarget;
    else                            pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  assign instrAddr  = pc;
  assign dataAddr   = aluRes;
  assign dataWrData = rtData;

  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (instrAddr == '0));
  a_r2_sequential_step: assert property (@(posedge clk) disable iff (rst)
    (!strb.jump && !strb.branch) |=> (instrAddr == $past(instrAddr) + DATA_W'(4)));
  a_r6_taken_target: assert property (@(posedge clk) disable iff (rst)
    (strb.branch && rsData == rtData) |=>
      (instrAddr == $past(instrAddr) + DATA_W'(4) + {$past(immExt[DATA_W-3:0]), 2'b00}));
  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
    strb.jump |=> (instrAddr[27:0] == {$past(instrData[25:0]), 2'b00}
                   && instrAddr[DATA_W-1:28] == $past(instrAddr[DATA_W-1:28])));
  a_r8_zero_source: assert property (@(posedge clk) disable iff (rst)
    (strb.memWrite && instrData[20:16] == 5'd0) |-> (dataWrData == '0));
  a_r10_store_only: assert property (@(posedge clk) disable iff (rst)
    strb.memWrite |-> (instrData[31:26] == OP_STORE));
  a_r5_store_no_reg: assert property (@(posedge clk) disable iff (rst)
    strb.memWrite |-> !strb.regWrite);
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] instrAddr,
  input  logic [DATA_W-1:0] instrData,
  output logic [DATA_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataWrData,
  output logic              dataWe,
  input  logic [DATA_W-1:0] dataRdData
);
  ctrlStrobes_t strb;

  sc_ctrl u_ctrl (
    .opcode (instrData[31:26]),
    .funct  (instrData[5:0]),
    .strb   (strb)
  );

  sc_dpath #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .instrAddr  (instrAddr),
    .instrData  (instrData),
    .dataAddr   (dataAddr),
    .dataWrData (dataWrData),
    .dataRdData (dataRdData)
  );

  assign dataWe = strb.memWrite;
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrAddr, instrData, dataAddr, dataWrData, dataRdData;
  logic        dataWe;

  logic [31:0] imem [1024];
  logic [31:0] dmem [512];
  string       instrTag [1024];

  logic [31:0] mRegs [32];
  logic [31:0] mMem  [512];
  logic [31:0] mPc;
  string       pcTag;

  int checks = 0, failures = 0, progIdx = 0, slotIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst(rst), .instrAddr(instrAddr), .instrData(instrData),
    .dataAddr(dataAddr), .dataWrData(dataWrData), .dataWe(dataWe),
    .dataRdData(dataRdData)
  );

  assign instrData  = imem[instrAddr[11:2]];
  assign dataRdData = dmem[dataAddr[10:2]];
  always @(posedge clk) if (dataWe) dmem[dataAddr[10:2]] <= dataWrData;

  function automatic logic [31:0] rtype(logic [5:0] fn, int rs, int rt, int rd);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic emit(logic [31:0] w, string tag);
    imem[progIdx] = w;
    instrTag[progIdx] = tag;
    progIdx++;
  endtask
  task automatic storeSlot(int rt, string tag);
    emit(itype(6'b101011, 0, rt, 32'h100 + slotIdx * 4), tag);
    slotIdx++;
  endtask

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare ports with the reference state, then advance the reference
  task automatic stepAndCheck();
    logic [31:0] w, a, b, ext, res, addr;
    logic [5:0]  op, fn;
    int idx;
    logic ok;
    idx = int'(mPc[11:2]);
    w = imem[idx];
    op = w[31:26]; fn = w[5:0];
    a = mRegs[w[25:21]]; b = mRegs[w[20:16]];
    ext = {{16{w[15]}}, w[15:0]};
    check(instrAddr, mPc, pcTag, "pc");
    check({31'd0, dataWe}, {31'd0, op == 6'b101011},
          (op == 6'b101011) ? "R5" : "R10", "we");
    if (op == 6'b101011) begin
      check(dataAddr, a + ext, "R5", "store addr");
      check(dataWrData, b, instrTag[idx], "store data");
    end
    if (op == 6'b100011) check(dataAddr, a + ext, "R4", "load addr");
    pcTag = "R2";
    mPc = mPc + 4;
    case (op)
      6'b000000: begin
        ok = 1'b1; res = '0;
        case (fn)
          6'b100000: res = a + b;
          6'b100010: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: begin ok = 1'b0; pcTag = "R9"; end
        endcase
        if (ok && w[15:11] != 5'd0) mRegs[w[15:11]] = res;
      end
      6'b100011: begin
        addr = a + ext;
        if (w[20:16] != 5'd0) mRegs[w[20:16]] = mMem[addr[10:2]];
      end
      6'b101011: begin
        addr = a + ext;
        mMem[addr[10:2]] = b;
      end
      6'b000100: begin
        pcTag = "R6";
        if (a == b) mPc = mPc + {ext[29:0], 2'b00};
      end
      6'b000010: begin
        pcTag = "R7";
        mPc = {mPc[31:28] , w[25:0], 2'b00};
      end
      default: pcTag = "R9";
    endcase
  endtask

  initial begin
    logic [5:0] fns [5];
    int haltAddr, loopAt, cycles, haltHits;
    fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
    fns[3] = 6'b100101; fns[4] = 6'b101010;
    for (int i = 0; i < 1024; i++) begin imem[i] = '0; instrTag[i] = "R2"; end
    for (int i = 0; i < 512; i++) dmem[i] = '0;
    dmem[0] = 32'd5;        dmem[1] = 32'hFFFF_FFFD; dmem[2] = 32'h7FFF_FFFF;
    dmem[3] = 32'h8000_0000; dmem[4] = 32'd0;        dmem[5] = 32'h1234_5678;
    dmem[6] = 32'd3;        dmem[7] = 32'd1;         dmem[8] = 32'h40;
    dmem[15] = 32'hCAFE_0001;
    for (int i = 0; i < 512; i++) mMem[i] = dmem[i];
    for (int i = 0; i < 32; i++) mRegs[i] = '0;

    // operand loads, including a negative offset
    for (int r = 1; r <= 6; r++) emit(itype(6'b100011, 0, r, (r-1)*4), "R4");
    emit(itype(6'b100011, 0, 10, 24), "R4");
    emit(itype(6'b100011, 0, 11, 28), "R4");
    emit(itype(6'b100011, 0, 12, 32), "R4");
    emit(itype(6'b100011, 12, 13, -4), "R4");
    storeSlot(13, "R4");
    // R3: every operation over every operand pair
    for (int f = 0; f < 5; f++)
      for (int x = 1; x <= 6; x++)
        for (int y = 1; y <= 6; y++) begin
          emit(rtype(fns[f], x, y, 7), "R3");
          storeSlot(7, "R3");
        end
    // R8: register 0 stays zero
    emit(rtype(6'b100000, 1, 2, 0), "R8");
    storeSlot(0, "R8");
    emit(itype(6'b100011, 0, 0, 0), "R8");
    storeSlot(0, "R8");
    // R9: undefined opcode and function codes leave r9 at 5
    emit(rtype(6'b100000, 1, 0, 9), "R9");
    emit(itype(6'b001000, 1, 9, 7), "R9");
    emit(rtype(6'b100110, 1, 2, 9), "R9");
    emit(rtype(6'b001000, 1, 0, 9), "R9");
    storeSlot(9, "R9");
    // R6: forward taken and not-taken branches
    emit(itype(6'b000100, 1, 1, 2), "R6");
    storeSlot(1, "R6");
    storeSlot(2, "R6");
    storeSlot(3, "R6");
    emit(itype(6'b000100, 1, 2, 1), "R6");
    storeSlot(4, "R6");
    // R7: counted loop closed by a jump
    loopAt = progIdx;
    emit(rtype(6'b100010, 10, 11, 10), "R7");
    emit(itype(6'b000100, 10, 0, 1), "R6");
    emit({6'b000010, 26'(loopAt)}, "R7");
    storeSlot(10, "R7");
    // R6: loop closed by a backward branch
    emit(itype(6'b100011, 0, 10, 24), "R4");
    loopAt = progIdx;
    emit(rtype(6'b100010, 10, 11, 10), "R6");
    emit(itype(6'b000100, 10, 0, 1), "R6");
    emit(itype(6'b000100, 0, 0, loopAt - (progIdx + 1)), "R6");
    storeSlot(10, "R6");
    haltAddr = progIdx;
    emit({6'b000010, 26'(haltAddr)}, "R7");

    mPc = '0;
    pcTag = "R1";
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(instrAddr, 32'd0, "R1", "pc after reset");
    rst = 1'b0;
    cycles = 0; haltHits = 0;
    while (haltHits < 3 && cycles < WATCHDOG) begin
      #1;
      if (mPc == 32'(haltAddr * 4)) haltHits++;
      stepAndCheck();
      cycles++;
      @(negedge clk);
    end
    if (cycles >= WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: run did not reach the halt loop");
    end
    // final image of the store area against the reference
    for (int i = 64; i < 64 + slotIdx; i++)
      check(dmem[i], mMem[i], "R5", "memory image");
    // R1: reset from the middle of execution
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(instrAddr, 32'd0, "R1", "pc after late reset");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule